// File: doc/BRIEF.md
# Run-Time Configurable Multi-Controlled Inverter Stage

This block is one stage of a classical reversible network on four signal lines. Each beat carries a 4-bit state word together with a configuration. The configuration names one target line and a subset of the three remaining lines that act as controls. When every chosen control line is 1, the stage inverts the target line. Every other line, including the controls, leaves the stage as it entered.

With a nonempty control subset there are 28 legal configurations: four target choices, each with seven control subsets. Each legal configuration is a permutation of the sixteen state values that swaps fixed pairs of values and is its own inverse. Larger reversible functions are built by chaining many such stages, each with its own configuration.

An empty control subset is flagged as illegal. The word then passes through unchanged and an error flag goes out with it. Results are registered and appear one cycle after the beat is accepted.

Top module: `rcs_stage`

## Requirements
- R1: `tgt_sel` holds the index of the target line. Line 0 is the least significant bit of `in_data` and line 3 is the most significant.
- R2: Bit k of `ctrl_mask` selects the k-th non-target line, counting the non-target lines in ascending index order. For example, with target 1, bits 0, 1 and 2 select lines 0, 2 and 3.
- R3: With a nonempty mask, the target bit of the output is inverted exactly when all selected control lines are 1. All non-target bits equal the input bits.
- R4: With target 0 and mask 3'b111, only input values 14 and 15 swap; every other value maps to itself.
- R5: With target 3 and mask 3'b111, only input values 7 and 15 swap.
- R6: With target 0 and mask 3'b100 (line 3 as the only control), the pairs 8/9, 10/11, 12/13 and 14/15 swap and values 0 to 7 are fixed.
- R7: For every legal configuration, feeding the output back through the stage with the same configuration returns the original word.
- R8: A zero `ctrl_mask` is illegal. The output word equals the input word and `out_err` is 1 in the same cycle as `out_valid`. `out_err` is 0 for legal beats and whenever `out_valid` is 0.
- R9: Each beat accepted with `in_valid` high appears on `out_data` with `out_valid` high exactly one clock later. `out_valid` is 0 in the cycle after a cycle with `in_valid` low.
- R10: After reset `out_valid`, `out_err` and `out_data` are 0. While `in_valid` is low, `out_data` holds its last value whatever the other inputs do.
- R11: With target 0 and mask 3'b011 (lines 1 and 2 as controls), values 6/7 and 14/15 swap and all others are fixed. This is the three-line doubly controlled inverter embedded in four lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present on the inputs |
| in_data | input | 4 | State word, line 0 at bit 0 |
| tgt_sel | input | 2 | Target line index |
| ctrl_mask | input | 3 | Control subset over the non-target lines |
| out_valid | output | 1 | Registered beat present |
| out_data | output | 4 | Registered result word |
| out_err | output | 1 | The registered beat used an illegal configuration |

## Verification
Two things can meet in one output cycle: the error path for an illegal configuration and the ordinary flow of a beat through the register. The bench provokes this by sending zero-mask beats back to back with legal beats inside the random stream, and by following a zero-mask beat with an idle cycle. It judges each output cycle on its own terms. An illegal beat must show its unchanged word with the error flag set. The legal beat that follows must clear the flag and carry its own permuted word. The idle cycle must drop both valid and error while the word holds.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
  parameter int unsigned RCS_LINES = 4;
  localparam int unsigned RCS_SEL_W = $clog2(RCS_LINES);
  localparam int unsigned RCS_CTRL_W = RCS_LINES - 1;

  typedef logic [RCS_LINES-1:0]  word_t;
  typedef logic [RCS_SEL_W-1:0]  sel_t;
  typedef logic [RCS_CTRL_W-1:0] mask_t;

  // One-hot position of the target line.
  function automatic word_t tgt_onehot(sel_t s);
    return word_t'(1) << s;
  endfunction

  // Spread a relative control mask onto absolute lines, skipping the target.
  function automatic word_t expand_ctrl(sel_t s, mask_t m);
    word_t mw;
    word_t low;
    word_t high;
    mw   = word_t'(m);
    low  = mw & ((word_t'(1) << s) - word_t'(1));
    high = ((mw >> s) << s) << 1;
    return low | high;
  endfunction

  function automatic logic cfg_is_illegal(sel_t s, mask_t m);
    return (m == '0) || (int'(s) >= int'(RCS_LINES));
  endfunction

  // Full stage function on one word.
  function automatic word_t apply_gate(word_t d, sel_t s, mask_t m);
    word_t c;
    c = expand_ctrl(s, m);
    if (!cfg_is_illegal(s, m) && ((d & c) == c))
      return d ^ tgt_onehot(s);
    return d;
  endfunction
endpackage

// File: rtl/rcs_cfg_decode.sv
`timescale 1ns/1ps
module rcs_cfg_decode
  import rcs_pkg::*;
(
  input  sel_t  tgt_sel,
  input  mask_t ctrl_mask,
  output word_t tgt_line,
  output word_t ctrl_lines,
  output logic  cfg_bad
);
  assign tgt_line   = tgt_onehot(tgt_sel);
  assign ctrl_lines = expand_ctrl(tgt_sel, ctrl_mask);
  assign cfg_bad    = cfg_is_illegal(tgt_sel, ctrl_mask);
endmodule

// File: rtl/rcs_flip_core.sv
`timescale 1ns/1ps
module rcs_flip_core
  import rcs_pkg::*;
(
  input  word_t din,
  input  word_t tgt_line,
  input  word_t ctrl_lines,
  input  logic  cfg_bad,
  output word_t dout,
  output logic  fire
);
  logic ctrl_all_set;

  assign ctrl_all_set = ((din & ctrl_lines) == ctrl_lines);
  assign fire         = !cfg_bad && ctrl_all_set;

  for (genvar i = 0; i < int'(RCS_LINES); i++) begin : g_line
    assign dout[i] = din[i] ^ (tgt_line[i] & fire);
  end
endmodule

// File: rtl/rcs_out_reg.sv
`timescale 1ns/1ps
module rcs_out_reg
  import rcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t d_nxt,
  input  logic  err_nxt,
  output logic  out_valid,
  output word_t out_data,
  output logic  out_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & err_nxt;
      if (in_valid)
        out_data <= d_nxt;
    end
  end
endmodule

// File: rtl/rcs_stage.sv
`timescale 1ns/1ps
module rcs_stage
  import rcs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [RCS_LINES-1:0]  in_data,
  input  logic [RCS_SEL_W-1:0]  tgt_sel,
  input  logic [RCS_CTRL_W-1:0] ctrl_mask,
  output logic                  out_valid,
  output logic [RCS_LINES-1:0]  out_data,
  output logic                  out_err
);
  word_t tgt_line;
  word_t ctrl_lines;
  logic  cfg_bad;
  word_t d_nxt;
  logic  core_fire;

  rcs_cfg_decode u_dec (
    .tgt_sel    (tgt_sel),
    .ctrl_mask  (ctrl_mask),
    .tgt_line   (tgt_line),
    .ctrl_lines (ctrl_lines),
    .cfg_bad    (cfg_bad)
  );

  rcs_flip_core u_core (
    .din        (in_data),
    .tgt_line   (tgt_line),
    .ctrl_lines (ctrl_lines),
    .cfg_bad    (cfg_bad),
    .dout       (d_nxt),
    .fire       (core_fire)
  );

  rcs_out_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d_nxt     (d_nxt),
    .err_nxt   (cfg_bad),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_err   (out_err)
  );
endmodule

// File: rtl/rcs_stage_chk.sv
`timescale 1ns/1ps
module rcs_stage_chk
  import rcs_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [RCS_LINES-1:0]  in_data,
  input logic [RCS_CTRL_W-1:0] ctrl_mask,
  input logic                  out_valid,
  input logic [RCS_LINES-1:0]  out_data,
  input logic                  out_err,
  input logic                  fire,
  input logic                  cfg_bad
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R10
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ($countones(out_data ^ $past(in_data)) <= 1)); // R3
  AST_FIRE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && fire) |=> (out_data != $past(in_data))); // R3
  AST_BAD_PASS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && ctrl_mask == '0) |=> (out_err && out_data == $past(in_data))); // R8
  AST_ERR_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_err |-> out_valid); // R8
  AST_BAD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n) cfg_bad |-> !fire); // R8
endmodule

bind rcs_stage rcs_stage_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .ctrl_mask (ctrl_mask),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err),
  .fire      (core_fire),
  .cfg_bad   (cfg_bad)
);

// File: tb/rcs_stage_test.sv
`timescale 1ns/1ps
module rcs_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = '0;
  logic [1:0] tgt_sel = '0;
  logic [2:0] ctrl_mask = '0;
  logic       out_valid;
  logic [3:0] out_data;
  logic       out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rcs_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tgt_sel(tgt_sel), .ctrl_mask(ctrl_mask),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  // Bench model: walk the non-target lines, consuming mask bits in order.
  function automatic logic [3:0] ref_gate(logic [3:0] d, int t, logic [2:0] m);
    int k = 0;
    bit all_one = 1;
    if (m == 3'b000) return d;
    for (int ln = 0; ln < 4; ln++) begin
      if (ln != t) begin
        if (m[k] && !d[ln]) all_one = 0;
        k++;
      end
    end
    if (all_one) d[t] = ~d[t];
    return d;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one beat at a falling edge; return outputs one clock later.
  task automatic beat(input logic [3:0] d, input int t, input logic [2:0] m,
                      output logic [3:0] y, output logic e, output logic v);
    in_valid  = 1'b1;
    in_data   = d;
    tgt_sel   = 2'(t);
    ctrl_mask = m;
    @(negedge clk);
    y = out_data;
    e = out_err;
    v = out_valid;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] y, z, hold;
    logic e, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 reset valid", out_valid, 0);
    chk(out_err == 0, "R10 reset err", out_err, 0);
    chk(out_data == 0, "R10 reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: latency, valid appears only after the edge
    in_valid = 1'b1; in_data = 4'd5; tgt_sel = 2'd2; ctrl_mask = 3'b001;
    #1;
    chk(out_valid == 0, "R9 not before edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R9 one cycle", out_valid, 1);
    chk(out_data == ref_gate(4'd5, 2, 3'b001), "R9 data", out_data, ref_gate(4'd5, 2, 3'b001));

    // Sweep of all legal configurations and all inputs
    for (int t = 0; t < 4; t++) begin
      for (int m = 1; m < 8; m++) begin
        for (int d = 0; d < 16; d++) begin
          logic [3:0] ex;
          ex = ref_gate(4'(d), t, 3'(m));
          beat(4'(d), t, 3'(m), y, e, v);
          chk(y == ex, "R1 R2 R3 sweep", y, ex);
          chk(v == 1 && e == 0, "R8 R9 legal flags", {v, e}, 2);
          if (t == 0 && m == 7) begin
            ex = (d == 14) ? 4'd15 : (d == 15) ? 4'd14 : 4'(d);
            chk(y == ex, "R4 swap 14/15", y, ex);
          end
          if (t == 3 && m == 7) begin
            ex = (d == 7) ? 4'd15 : (d == 15) ? 4'd7 : 4'(d);
            chk(y == ex, "R5 swap 7/15", y, ex);
          end
          if (t == 0 && m == 4) begin
            ex = (d >= 8) ? 4'(d ^ 1) : 4'(d);
            chk(y == ex, "R6 pairs above 7", y, ex);
          end
          if (t == 0 && m == 3) begin
            ex = ((d & 6) == 6) ? 4'(d ^ 1) : 4'(d);
            chk(y == ex, "R11 doubly controlled", y, ex);
          end
          beat(y, t, 3'(m), z, e, v);
          chk(z == 4'(d), "R7 twice is identity", z, d);
        end
      end
    end

    // R8 illegal mask, then idle cycle with R10 hold
    for (int t = 0; t < 4; t++) begin
      logic [3:0] d;
      d = 4'($urandom_range(0, 15));
      beat(d, t, 3'b000, y, e, v);
      chk(y == d, "R8 pass unchanged", y, d);
      chk(e == 1 && v == 1, "R8 err with valid", {v, e}, 3);
      hold = y;
      in_valid = 1'b0; in_data = ~d; ctrl_mask = 3'b111;
      @(negedge clk);
      chk(out_valid == 0 && out_err == 0, "R9 R8 idle flags", {out_valid, out_err}, 0);
      chk(out_data == hold, "R10 hold idle", out_data, hold);
    end

    // Random stream, illegal beats mixed in back to back
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d;
      logic [2:0] m;
      int t;
      d = 4'($urandom_range(0, 15));
      m = 3'($urandom_range(0, 7));
      t = $urandom_range(0, 3);
      beat(d, t, m, y, e, v);
      chk(y == ref_gate(d, t, m), "R3 random", y, ref_gate(d, t, m));
      chk(e == (m == 0), "R8 random err", e, (m == 0));
      if (i % 37 == 0) begin
        hold = y;
        in_valid = 1'b0; in_data = ~in_data;
        @(negedge clk);
        chk(out_valid == 0 && out_data == hold, "R10 random idle", out_data, hold);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule